// File: doc/BRIEF.md
# Interrupt Cause Coalescing Controller

This block collects single-cycle event pulses from DMA, firmware and hardware sources into a 32-bit sticky cause register. It drives one level-sensitive host interrupt line. Software reaches the block over a simple 32-bit register bus. It reads the pending causes, acknowledges them by writing ones, chooses which causes may raise the line through an enable mask, and programs a coalescing word.

The low byte of the coalescing word holds a delay in ticks of 32 µs. The reset value is 0x40, which is 2048 µs. After the first enabled ordinary cause appears, the line is held back for that many ticks, so that a burst of events costs the host one interrupt. The dedicated high-priority receive cause skips this delay. The second byte of the word sets the period of a generator that posts a receive-periodic cause every N ticks. A value of zero turns the generator off.

A free-running divider makes the tick. The parameter `TICK_DIV` gives the number of clock cycles per tick, which is 1600 for 32 µs at 50 MHz.

Top module: `icc_irq_coalescer`

## Requirements
- R1: After reset, the cause register (byte offset 0x0) reads 0, the mask register (offset 0x4) reads 0, and the coalescing word (offset 0x8) reads 0x0000_0040: delay 0x40 in bits 7:0, period 0 in bits 15:8, and bits 31:16 always read as zero.
- R2: A one on bit i of `evt_i` in a cycle sets cause bit i at the next clock edge, and the bit stays set until the host clears it. Cause positions used: 31 receive DMA, 30 high-priority receive, 28 receive periodic, 27 transmit DMA, 25 firmware error, 7 RF-kill toggle, 1 wake-up, 0 firmware alive.
- R3: A write to offset 0x0 clears exactly the cause bits written as one; bits written as zero keep their value.
- R4: When an event and a host clear hit the same cause bit in the same cycle, the bit ends up set.
- R5: A cause whose mask bit is zero never drives `irq_o`, even though it stays pending and readable.
- R6: When an enabled cause other than bit 30 becomes pending while no delay is running, a count of D ticks starts, where D is the coalescing delay and is nonzero. `irq_o` rises after the D-th tick: at least (D-1)·TICK_DIV and at most D·TICK_DIV+4 cycles after the cause is set. Events during the count do not restart it.
- R7: With a coalescing delay of 0, `irq_o` rises at the second clock edge after the edge that sets an enabled cause.
- R8: An enabled high-priority receive cause (bit 30) raises `irq_o` at the first clock edge after it is pending, whatever the delay.
- R9: `irq_o` falls at the clock edge after the one where no enabled pending cause remains, either because the causes were cleared or because they were masked.
- R10: A nonzero period P in bits 15:8 of the coalescing word sets cause bit 28 once every P ticks. A period of 0 never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one per cause bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Host interrupt line, level |

## Verification
The hardest cases to reach from the ports are where the tick phase meets the register timing. In these cases a delay count, a periodic pulse or a same-cycle set and clear lands on a particular edge. The stimulus drives event pulses and register writes on falling edges with a small tick divider. This lets delays of 3 and 0x40 ticks run to expiry and lets the periodic cause fire several times. A behavioural model steps through every clock and compares the line and the addressed register on each one. Directed sequences place an event and a clear on the same bit in one cycle, and switch the period to zero while a pulse may still be in flight.

// File: rtl/icc_pkg.sv
package icc_pkg;
    localparam int DATA_W = 32;

    // register byte offsets
    localparam int OFS_CAUSE = 'h0;
    localparam int OFS_MASK  = 'h4;
    localparam int OFS_COAL  = 'h8;

    // cause positions
    localparam int BIT_RX_DMA      = 31;
    localparam int BIT_PRIO_RX     = 30;
    localparam int BIT_RX_PERIODIC = 28;
    localparam int BIT_TX_DMA      = 27;
    localparam int BIT_FW_ERR      = 25;
    localparam int BIT_RFKILL      = 7;
    localparam int BIT_WAKE        = 1;
    localparam int BIT_ALIVE       = 0;

    localparam int          FIELD_W     = 8;
    localparam logic [7:0]  DELAY_RESET = 8'h40;

    typedef enum logic [1:0] {
        CO_IDLE = 2'd0,
        CO_RUN  = 2'd1,
        CO_OPEN = 2'd2
    } coal_state_e;
endpackage

// File: rtl/icc_tick_gen.sv
module icc_tick_gen #(
    parameter int DIV = 1600
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = (s_q.cnt == CW'(DIV - 1));
        s_d.cnt  = s_d.tick ? '0 : s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;

    generate
        if (DIV > 1) begin : g_chk
            // R6: ticks are isolated single-cycle pulses
            a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.tick |=> !s_q.tick);
        end
    endgenerate
endmodule

// File: rtl/icc_periodic.sv
module icc_periodic #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    output logic             pulse_o
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             pulse;
    } per_st_t;

    per_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (tick_i) begin
            if (period_i == '0) begin
                s_d.cnt = '0;
            end else if (({1'b0, s_q.cnt} + 1'b1) >= {1'b0, period_i}) begin
                s_d.cnt   = '0;
                s_d.pulse = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = s_q.pulse;

    // R10: a zero period produces no periodic cause
    a_r10_period_off: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0) |=> !pulse_o);
endmodule

// File: rtl/icc_coal_timer.sv
module icc_coal_timer
    import icc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             any_i,
    input  logic             np_i,
    input  logic             prio_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic             irq_o
);
    typedef struct packed {
        coal_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } co_st_t;

    co_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!any_i) begin
            s_d.state = CO_IDLE;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.state)
                CO_IDLE: begin
                    if (np_i) begin
                        if (delay_i == '0) begin
                            s_d.state = CO_OPEN;
                        end else begin
                            s_d.state = CO_RUN;
                            s_d.cnt   = delay_i;
                        end
                    end
                end
                CO_RUN: begin
                    if (tick_i) begin
                        if (s_q.cnt == CNT_W'(1)) begin
                            s_d.state = CO_OPEN;
                            s_d.cnt   = '0;
                        end else begin
                            s_d.cnt = s_q.cnt - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
        s_d.irq = any_i && ((s_q.state == CO_OPEN) || prio_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: CO_IDLE, cnt: '0, irq: 1'b0};
        else        s_q <= s_d;
    end

    assign irq_o = s_q.irq;

    // R6: a running delay always has ticks left to count
    a_r6_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == CO_RUN) |-> (s_q.cnt != '0));
endmodule

// File: rtl/icc_irq_coalescer.sv
module icc_irq_coalescer
    import icc_pkg::*;
#(
    parameter int TICK_DIV = 1600,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       evt_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0]  cause;
        logic [DATA_W-1:0]  mask;
        logic [FIELD_W-1:0] delay;
        logic [FIELD_W-1:0] period;
    } regs_t;

    regs_t r_d, r_q;

    logic tick;
    logic per_pulse;
    logic irq_int;
    logic hit_cause, hit_mask, hit_coal;
    logic [DATA_W-1:0] enabled;

    icc_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    icc_periodic #(.PER_W(FIELD_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .period_i (r_q.period),
        .pulse_o  (per_pulse)
    );

    assign enabled = r_q.cause & r_q.mask;

    icc_coal_timer #(.CNT_W(FIELD_W)) u_coal (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .any_i   (|enabled),
        .np_i    (|(enabled & ~(DATA_W'(1) << BIT_PRIO_RX))),
        .prio_i  (enabled[BIT_PRIO_RX]),
        .delay_i (r_q.delay),
        .irq_o   (irq_int)
    );

    assign hit_cause = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CAUSE));
    assign hit_mask  = reg_we_i && (reg_addr_i == ADDR_W'(OFS_MASK));
    assign hit_coal  = reg_we_i && (reg_addr_i == ADDR_W'(OFS_COAL));

    always_comb begin
        r_d = r_q;
        // the set terms come last so a simultaneous event beats the clear
        r_d.cause = (r_q.cause & ~(hit_cause ? reg_wdata_i : '0))
                  | evt_i
                  | (DATA_W'(per_pulse) << BIT_RX_PERIODIC);
        if (hit_mask) r_d.mask = reg_wdata_i;
        if (hit_coal) begin
            r_d.delay  = reg_wdata_i[FIELD_W-1:0];
            r_d.period = reg_wdata_i[2*FIELD_W-1:FIELD_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cause: '0, mask: '0, delay: DELAY_RESET, period: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (reg_addr_i)
            ADDR_W'(OFS_CAUSE): reg_rdata_o = r_q.cause;
            ADDR_W'(OFS_MASK):  reg_rdata_o = r_q.mask;
            ADDR_W'(OFS_COAL):  reg_rdata_o = {16'h0, r_q.period, r_q.delay};
            default:            reg_rdata_o = '0;
        endcase
    end

    assign irq_o = irq_int;

    // R2/R4: every event bit is present in the cause register one edge later
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((r_q.cause & $past(evt_i)) == $past(evt_i)));

    // R3: bits written as one are gone when nothing sets them again
    a_r3_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cause && (evt_i == '0) && !per_pulse) |=> ((r_q.cause & $past(reg_wdata_i)) == '0));

    // R8: an enabled priority cause raises the line on the next edge
    a_r8_prio_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cause[BIT_PRIO_RX] && r_q.mask[BIT_PRIO_RX]) |=> irq_o);

    // R9: no enabled pending cause means the line is low one edge later
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.cause & r_q.mask) == '0) |=> !irq_o);
endmodule

// File: tb/icc_irq_coalescer_bench.sv
module icc_irq_coalescer_bench;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    always #10 clk = ~clk;

    icc_irq_coalescer #(.TICK_DIV(DIV), .ADDR_W(4)) u_icc_irq_coalescer (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cause, m_mask, n_cause, en, clr;
    int m_delay, m_period, m_div, m_pcnt, m_state, m_cnt;
    int n_pcnt, n_state, n_cnt;
    bit m_tick, m_pulse, m_irq, n_pulse, n_irq, n_tick;

    function automatic logic [31:0] m_read(logic [3:0] a);
        case (a)
            4'h0:    return m_cause;
            4'h4:    return m_mask;
            4'h8:    return {16'h0, 8'(m_period), 8'(m_delay)};
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cause = '0; m_mask = '0; m_delay = 'h40; m_period = 0;
            m_div = 0; m_tick = 0; m_pcnt = 0; m_pulse = 0;
            m_state = 0; m_cnt = 0; m_irq = 0;
        end else begin
            en    = m_cause & m_mask;
            n_irq = (en != 0) && (m_state == 2 || en[30]);
            n_state = m_state; n_cnt = m_cnt;
            if (en == 0) begin
                n_state = 0; n_cnt = 0;
            end else if (m_state == 0) begin
                if ((en & ~32'h4000_0000) != 0) begin
                    if (m_delay == 0) n_state = 2;
                    else begin n_state = 1; n_cnt = m_delay; end
                end
            end else if (m_state == 1 && m_tick) begin
                if (m_cnt == 1) begin n_state = 2; n_cnt = 0; end
                else n_cnt = m_cnt - 1;
            end
            n_pulse = 0; n_pcnt = m_pcnt;
            if (m_tick) begin
                if (m_period == 0) n_pcnt = 0;
                else if (m_pcnt + 1 >= m_period) begin n_pcnt = 0; n_pulse = 1; end
                else n_pcnt = m_pcnt + 1;
            end
            clr     = (we && addr == 4'h0) ? wdata : '0;
            n_cause = (m_cause & ~clr) | evt | (m_pulse ? 32'h1000_0000 : 32'h0);
            if (we && addr == 4'h4) m_mask = wdata;
            if (we && addr == 4'h8) begin
                m_delay = int'(wdata[7:0]); m_period = int'(wdata[15:8]);
            end
            n_tick = (m_div == DIV - 1);
            m_div  = n_tick ? 0 : m_div + 1;
            m_tick = n_tick; m_cause = n_cause; m_pulse = n_pulse; m_pcnt = n_pcnt;
            m_state = n_state; m_cnt = n_cnt; m_irq = n_irq;
        end
    end

    // per-cycle comparison, shortly after each active edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R6 irq vs model", {31'h0, irq}, {31'h0, m_irq});
            check("R2 read vs model", rdata, m_read(addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0; addr = 4'h0; wdata = '0;
    endtask

    task automatic pulse(logic [31:0] b);
        @(negedge clk); evt = b;
        @(negedge clk); evt = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
        @(negedge clk); addr = 4'h0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n;
        idle(3);
        rst_n = 1'b1;
        // R1 reset values
        rd(4'h0, v); check("R1 cause reset", v, 32'h0);
        rd(4'h4, v); check("R1 mask reset", v, 32'h0);
        rd(4'h8, v); check("R1 coal reset", v, 32'h0000_0040);
        check("R1 irq reset", {31'h0, irq}, 32'h0);

        // enable bits 31,30,28,27,7,0
        wr(4'h4, 32'hD800_0081);
        wr(4'h8, 32'h0000_0000);
        // R7: delay zero
        pulse(32'h0000_0001);
        rd(4'h0, v); check("R2 sticky alive cause", v, 32'h0000_0001);
        check("R7 irq after two edges", {31'h0, irq}, 32'h1);
        idle(2);
        // R9: clear and watch fall
        @(negedge clk); we = 1'b1; addr = 4'h0; wdata = 32'h1;
        @(negedge clk); we = 1'b0; wdata = '0;
        check("R9 irq still high at clear edge", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R9 irq low edge after clear", {31'h0, irq}, 32'h0);

        // R3: clear only bits written as one
        pulse(32'h8000_0001);
        wr(4'h0, 32'h8000_0000);
        rd(4'h0, v); check("R3 partial clear", v, 32'h0000_0001);
        wr(4'h0, 32'hFFFF_FFFF);
        // R4: set beats clear on the same bit
        @(negedge clk); evt = 32'h2; pulse_clear: begin we = 1'b1; addr = 4'h0; wdata = 32'h3; end
        @(negedge clk); evt = '0; we = 1'b0; wdata = '0;
        rd(4'h0, v); check("R4 set wins", v, 32'h0000_0002);
        wr(4'h0, 32'hFFFF_FFFF);
        idle(3);

        // R8: priority bypass with long delay
        wr(4'h8, 32'h0000_0040);
        @(negedge clk); evt = 32'h4000_0000;
        @(negedge clk); evt = '0;
        check("R8 irq not yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq after one edge", {31'h0, irq}, 32'h1);
        wr(4'h0, 32'hFFFF_FFFF);
        idle(3);

        // R6: delay of 3 ticks
        wr(4'h8, 32'h0000_0003);
        pulse(32'h8000_0000);
        n = 0;
        while (!irq && n < 1000) begin @(negedge clk); n++; end
        check("R6 short delay lower bound", {31'h0, n >= 2 * DIV}, 32'h1);
        check("R6 short delay upper bound", {31'h0, n <= 3 * DIV + 4}, 32'h1);
        wr(4'h0, 32'hFFFF_FFFF);
        idle(3);
        // R6: default delay 0x40
        wr(4'h8, 32'h0000_0040);
        pulse(32'h0800_0000);
        n = 0;
        while (!irq && n < 2000) begin @(negedge clk); n++; end
        check("R6 default delay lower bound", {31'h0, n >= 63 * DIV}, 32'h1);
        check("R6 default delay upper bound", {31'h0, n <= 64 * DIV + 4}, 32'h1);
        wr(4'h0, 32'hFFFF_FFFF);
        idle(3);

        // R5: masked cause stays silent
        wr(4'h8, 32'h0000_0000);
        pulse(32'h0200_0000);
        idle(6);
        check("R5 masked cause no irq", {31'h0, irq}, 32'h0);
        rd(4'h0, v); check("R5 masked cause pending", v, 32'h0200_0000);
        wr(4'h4, 32'h0200_0000);
        idle(3);
        check("R5 unmasked cause raises irq", {31'h0, irq}, 32'h1);
        // R9: masking drops the line
        wr(4'h4, 32'h0000_0000);
        @(negedge clk);
        check("R9 irq low after mask", {31'h0, irq}, 32'h0);
        wr(4'h0, 32'hFFFF_FFFF);

        // R10: periodic cause every 2 ticks
        wr(4'h4, 32'h1000_0000);
        wr(4'h8, 32'h0000_0200);
        n = 0;
        while (!rdata[28] && n < 100) begin @(negedge clk); n++; end
        check("R10 periodic cause appears", {31'h0, n <= 2 * DIV + 4}, 32'h1);
        wr(4'h0, 32'h1000_0000);
        n = 0;
        while (!rdata[28] && n < 100) begin @(negedge clk); n++; end
        check("R10 periodic cause repeats", {31'h0, n <= 2 * DIV + 4}, 32'h1);
        wr(4'h8, 32'h0000_0000);
        idle(3);
        wr(4'h0, 32'hFFFF_FFFF);
        idle(10 * DIV);
        rd(4'h0, v); check("R10 period zero silent", v, 32'h0);
        check("R10 irq low", {31'h0, irq}, 32'h0);

        idle(2);
        finish_run();
    end
endmodule